// File: doc/BRIEF.md
# RGB Cursor and Border Color Register Bank

This block holds four 24-bit colors for a display pipeline: a border color shown outside the active picture, and three cursor colors. A host reaches them over a narrow byte bus. Each color is split into red, green and blue bytes, and all three bytes pass through one shared data address.

To load colors, the host writes the write-pointer address with a starting color number. It then writes bytes to the data address in the order red, green, blue. After each blue byte the block moves on to the next color. Reading works the same way through the read-pointer address. Four colors can therefore be loaded with one pointer write followed by twelve data writes.

All four colors drive output ports at all times. A color that is only partly written shows each new byte on its port as soon as that byte arrives.

Top module: `color_reg_bank`

## Requirements
- R1: After reset, all four color outputs are zero and `bus_rdata` is zero. The color pointer is color 0 and the byte step is red.
- R2: A write to the write-pointer address (4'b0100) or the read-pointer address (4'b0111) loads the color pointer from `bus_wdata[1:0]`. Upper data bits are ignored, and the byte step returns to red.
- R3: The pointer numbers colors as follows: 0 is the border, 1 is cursor A, 2 is cursor B and 3 is cursor C. A write to the data address (4'b0101) stores the byte in the selected color's field for the current step. Red goes to [23:16], green to [15:8] and blue to [7:0]. The step then advances.
- R4: A data transfer made at the blue step returns the step to red and moves the pointer to the next color. After color 3 the pointer wraps to color 0.
- R5: Each color port shows a written byte on the cycle after the write strobe. A color's other bytes and all other colors keep their values.
- R6: A pointer write made in the middle of a red-green-blue sequence discards the partial sequence. The next data byte is treated as red.
- R7: A read strobe at the data address returns the selected color's byte for the current step on `bus_rdata` in the following cycle. It advances step and pointer the same way as a write.
- R8: A read strobe at any other address returns zero and leaves the step and pointer unchanged. A write strobe at any address other than the three listed changes no color, step or pointer.
- R9: When read and write strobes arrive in the same cycle, only the write is performed. `bus_rdata` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| border_rgb | output | 24 | Border color |
| cursor_a_rgb | output | 24 | Cursor color for pointer 1 |
| cursor_b_rgb | output | 24 | Cursor color for pointer 2 |
| cursor_c_rgb | output | 24 | Cursor color for pointer 3 |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 4-bit address and the three register addresses given above. With a 16-entry address space, the bench can strobe every unused address once for both reads and writes. With a 2-bit pointer, a short stream of data transfers crosses the wrap from color 3 back to color 0 several times, in both directions. Starting pointers are also written with upper data bits set, so the test shows that only the two low bits select a color.

// File: rtl/color_reg_bank.sv
module color_reg_bank #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter logic [AW-1:0] WPTR_ADDR = 4'b0100,
  parameter logic [AW-1:0] DATA_ADDR = 4'b0101,
  parameter logic [AW-1:0] RPTR_ADDR = 4'b0111
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [3*DW-1:0] border_rgb,
  output logic [3*DW-1:0] cursor_a_rgb,
  output logic [3*DW-1:0] cursor_b_rgb,
  output logic [3*DW-1:0] cursor_c_rgb
);
  localparam int NCOL = 4;
  localparam int IW = $clog2(NCOL);
  localparam int CW = 3 * DW;

  logic [CW-1:0] col [NCOL];
  logic [IW-1:0] ptr;
  logic [1:0]    step;
  logic [DW-1:0] cur_byte;

  wire ptr_wr  = bus_wr && (bus_addr == WPTR_ADDR || bus_addr == RPTR_ADDR);
  wire data_wr = bus_wr && bus_addr == DATA_ADDR;
  wire rd_only = bus_rd && !bus_wr;
  wire data_rd = rd_only && bus_addr == DATA_ADDR;
  wire advance = data_wr || data_rd;
  wire at_blue = step == 2'd2;
  wire [IW-1:0] ptr_nxt = (ptr == IW'(NCOL - 1)) ? '0 : ptr + 1'b1;

  assign border_rgb   = col[0];
  assign cursor_a_rgb = col[1];
  assign cursor_b_rgb = col[2];
  assign cursor_c_rgb = col[3];

  always_comb begin
    case (step)
      2'd0:    cur_byte = col[ptr][3*DW-1:2*DW];
      2'd1:    cur_byte = col[ptr][2*DW-1:DW];
      default: cur_byte = col[ptr][DW-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      step <= 2'd0;
    end else if (ptr_wr) begin
      ptr  <= bus_wdata[IW-1:0];
      step <= 2'd0;
    end else if (advance) begin
      step <= at_blue ? 2'd0 : step + 2'd1;
      if (at_blue) ptr <= ptr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCOL; c++) col[c] <= '0;
    end else if (data_wr) begin
      case (step)
        2'd0:    col[ptr][3*DW-1:2*DW] <= bus_wdata;
        2'd1:    col[ptr][2*DW-1:DW]   <= bus_wdata;
        default: col[ptr][DW-1:0]      <= bus_wdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bus_rdata <= '0;
    else if (rd_only) bus_rdata <= data_rd ? cur_byte : '0;
  end

  a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> (step == 2'd0 && ptr == $past(bus_wdata[IW-1:0])));

  a_r3_step_legal: assert property (@(posedge clk) disable iff (!rst_n)
    step != 2'd3);

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !ptr_wr && at_blue && ptr == IW'(NCOL - 1)) |=> (ptr == '0 && step == 2'd0));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> ($stable(border_rgb) && $stable(cursor_a_rgb) &&
                  $stable(cursor_b_rgb) && $stable(cursor_c_rgb)));

  a_r8_rd_other: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && bus_addr != DATA_ADDR) |=> (bus_rdata == '0 && $stable(ptr) && $stable(step)));

  a_r9_wr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rd) |=> $stable(bus_rdata));
endmodule

// File: tb/test_color_reg_bank.sv
module test_color_reg_bank;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] WA = 4'b0100, DA = 4'b0101, RA = 4'b0111;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [23:0] border_rgb, cursor_a_rgb, cursor_b_rgb, cursor_c_rgb;

  color_reg_bank i_color_reg_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .border_rgb(border_rgb), .cursor_a_rgb(cursor_a_rgb),
    .cursor_b_rgb(cursor_b_rgb), .cursor_c_rgb(cursor_c_rgb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [23:0] m_col [4];
  logic [1:0]  m_ptr = 0;
  int          m_step = 0;
  logic [7:0]  exp_q [$];
  string       tag_q [$];
  logic        pend = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_colors(input string tag);
    check(border_rgb   == m_col[0], tag, border_rgb,   m_col[0]);
    check(cursor_a_rgb == m_col[1], tag, cursor_a_rgb, m_col[1]);
    check(cursor_b_rgb == m_col[2], tag, cursor_b_rgb, m_col[2]);
    check(cursor_c_rgb == m_col[3], tag, cursor_c_rgb, m_col[3]);
  endtask

  function automatic void step_model();
    if (m_step == 2) begin m_step = 0; m_ptr = m_ptr + 1; end
    else m_step++;
  endfunction

  task automatic bwr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    if (a == WA || a == RA) begin m_ptr = d[1:0]; m_step = 0; end
    else if (a == DA) begin m_col[m_ptr][(2-m_step)*8 +: 8] = d; step_model(); end
  endtask

  task automatic brd(input logic [3:0] a, input string tag);
    logic [7:0] e;
    if (a == DA) begin e = m_col[m_ptr][(2-m_step)*8 +: 8]; step_model(); end
    else e = '0;
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
  endtask

  always @(posedge clk) pend <= bus_rd && !bus_wr;

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) check(0, "scoreboard underflow", bus_rdata, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) m_col[c] = '0;
    @(negedge clk); @(negedge clk);
    check_colors("R1 reset colors");
    check(bus_rdata == 0, "R1 reset rdata", bus_rdata, 0);
    rst_n = 1;
    @(negedge clk);
    brd(DA, "R1 reset pointer/step read");
    brd(DA, "R1 reset second byte");

    bwr(WA, 8'h00);
    for (int i = 0; i < 12; i++) bwr(DA, 8'h10 + 8'(i * 7));
    check_colors("R3 R4 full load of four colors");

    bwr(WA, 8'hFA);
    bwr(DA, 8'hA1); check_colors("R5 red visible after one byte");
    bwr(DA, 8'hA2); check_colors("R5 green visible");
    bwr(DA, 8'hA3); check_colors("R2 R3 upper pointer bits ignored");
    for (int i = 0; i < 6; i++) bwr(DA, 8'hC0 + 8'(i));
    check_colors("R4 wrap from color 3 to border");

    bwr(WA, 8'h01);
    bwr(DA, 8'h55); bwr(DA, 8'h66);
    bwr(RA, 8'h01);
    bwr(DA, 8'h77);
    check_colors("R6 pointer write restarts at red");
    check(cursor_a_rgb[23:16] == 8'h77, "R6 byte landed in red", cursor_a_rgb, 24'h77);

    bwr(RA, 8'h02);
    for (int i = 0; i < 12; i++) brd(DA, "R7 sequential read across wrap");
    brd(DA, "R7 read after wrap");

    for (int a = 0; a < 16; a++) begin
      if (a == int'(WA) || a == int'(DA) || a == int'(RA)) continue;
      bwr(4'(a), 8'hEE);
      brd(4'(a), "R8 read of unused address returns zero");
    end
    check_colors("R8 unused writes leave colors");
    brd(DA, "R8 step/pointer unchanged by unused accesses");

    @(negedge clk);
    begin
      logic [7:0] prev;
      prev = bus_rdata;
      bus_addr = DA; bus_wdata = 8'h3C; bus_wr = 1; bus_rd = 1;
      @(negedge clk);
      bus_wr = 0; bus_rd = 0;
      m_col[m_ptr][(2-m_step)*8 +: 8] = 8'h3C; step_model();
      check(bus_rdata == prev, "R9 rdata held when both strobes", bus_rdata, prev);
      check_colors("R9 write performed when both strobes");
      brd(DA, "R9 pointer advanced once");
    end

    @(negedge clk); @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule